// File: doc/BRIEF.md
# Bit-Addressable Internal Data Memory

This block is the on-chip data store and special-register space of a small 8-bit controller core. It holds two 128-byte RAM halves and twenty-one special registers. The core reaches it with byte accesses (direct, pointer-based through R0 or R1, or by register number R0–R7) and with single-bit operations. Register numbers are turned into RAM addresses through the bank field of the status register. A direct access to the top half of the address space lands on the special registers. A pointer access to the same addresses lands on the upper RAM half.

A separate 256-entry bit-address space is folded onto storage. Its lower half covers the sixteen RAM bytes from 20h up. Its upper half covers the special registers whose byte address is a multiple of eight. Every operation completes in the clock cycle it is presented. Read data, the bit result and an error pulse are combinational from the request. Writes, including the read-modify-write of a bit operation, take effect at the closing clock edge.

Top module: `idata_space`

## Requirements
- R1: A bit address b below 80h selects bit b[2:0] of lower-RAM byte 20h + (b >> 3).
- R2: A bit address b of 80h or above selects bit b[2:0] of the special register at byte address b AND F8h. The bit-addressable registers are 80h, 88h, 90h, 98h, A0h, A8h, B0h, B8h, D0h, E0h and F0h. A bit operation aimed at any other multiple of eight does nothing, returns bit 0 and raises err_o for that cycle.
- R3: A direct byte access (op 1 read, op 2 write) to 00h–7Fh uses lower RAM, and one to 80h–FFh uses the special registers. A pointer access (op 3 read, op 4 write) whose pointer is 80h or above uses a separate upper RAM. A pointer below 80h uses lower RAM.
- R4: A register access (op 5 read, op 6 write) to Rn reaches lower-RAM byte 8×bank + n. The bank is bits 4:3 of the status register at D0h. After reset the bank is 0.
- R5: A pointer access takes its pointer from R0 (rsel_i = 0) or R1 (rsel_i = 1) of the active bank. With rsel_i of 2 to 7 it writes nothing, returns 00h and raises err_o.
- R6: The bit operations are read (op 8), set (op 9), clear (op 10), complement (op 11) and test-and-clear (op 12). Each returns the bit's previous value on bit_o. Only the addressed bit changes. Test-and-clear leaves the bit at 0.
- R7: The implemented special registers are at 80h–83h, 87h–8Dh, 90h, 98h, 99h, A0h, A8h, B0h, B8h, D0h, E0h and F0h. A direct read of any other address from 80h up returns 00h, and a write there changes nothing. Both raise err_o.
- R8: Reset is synchronous and active high. After reset the register at 81h holds 07h and the registers at 80h, 90h, A0h and B0h hold FFh. All other special registers hold 00h.
- R9: Every operation completes in one clock. The next cycle's operation sees its result, including consecutive bit operations on the same byte and a bank change followed at once by a register access.
- R10: For op 0 and the unused codes 7 and 13–15 nothing is written, rdata_o and bit_o are 0 and err_o stays low. rdata_o is 00h for all write and bit operations, and bit_o is 0 for all byte operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code (see R3–R6, R10) |
| addr_i | input | 8 | Byte address for direct access, bit address for bit operations |
| rsel_i | input | 3 | Register number for register and pointer accesses |
| wdata_i | input | 8 | Write data for byte writes |
| rdata_o | output | 8 | Read data of byte reads |
| bit_o | output | 1 | Previous value of the addressed bit |
| err_o | output | 1 | One-cycle flag for a reserved, non-bit-addressable or illegal-pointer request |

## Verification
The bit mapping is swept over all 256 bit addresses. Each address gets set, read, complement, test-and-clear and a second read, so a wrong byte, a wrong bit position or a disturbed neighbour shows up against an independent model of the memory. Byte traffic uses distinct fill patterns in lower and upper RAM. A direct write and a pointer write both aimed at 90h show whether the two paths really reach separate storage. Register accesses in all four banks, with the bank switched by both byte and bit writes, separate the bank arithmetic from the register number. Reads of every address from 80h up tell implemented registers from reserved ones and check the reset values.

// File: rtl/idata_pkg.sv
package idata_pkg;

    localparam int DW        = 8;
    localparam int RAM_DEPTH = 128;
    localparam int RAM_AW    = $clog2(RAM_DEPTH);
    localparam int NUM_SFR   = 21;

    typedef enum logic [3:0] {
        OP_IDLE    = 4'd0,
        OP_DIR_RD  = 4'd1,
        OP_DIR_WR  = 4'd2,
        OP_IND_RD  = 4'd3,
        OP_IND_WR  = 4'd4,
        OP_REG_RD  = 4'd5,
        OP_REG_WR  = 4'd6,
        OP_BIT_RD  = 4'd8,
        OP_BIT_SET = 4'd9,
        OP_BIT_CLR = 4'd10,
        OP_BIT_CPL = 4'd11,
        OP_BIT_TCL = 4'd12
    } op_e;

    typedef enum logic [1:0] {TGT_NONE, TGT_LO, TGT_HI, TGT_SFR} tgt_e;

    typedef struct packed {
        tgt_e          tgt;
        logic [DW-1:0] addr;
        logic          is_bit;
        logic [2:0]    bpos;
        logic          rd;
        logic          wr;
        logic          err;
    } acc_t;

    localparam logic [7:0] ADR_STATUS = 8'hD0;
    localparam logic [7:0] ADR_STACK  = 8'h81;

    function automatic logic [7:0] sfr_slot_addr(input int i);
        case (i)
            0: return 8'h80;  1: return 8'h81;  2: return 8'h82;
            3: return 8'h83;  4: return 8'h87;  5: return 8'h88;
            6: return 8'h89;  7: return 8'h8A;  8: return 8'h8B;
            9: return 8'h8C; 10: return 8'h8D; 11: return 8'h90;
           12: return 8'h98; 13: return 8'h99; 14: return 8'hA0;
           15: return 8'hA8; 16: return 8'hB0; 17: return 8'hB8;
           18: return 8'hD0; 19: return 8'hE0; 20: return 8'hF0;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic sfr_is_impl(input logic [7:0] a);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < NUM_SFR; i++)
            if (a == sfr_slot_addr(i)) hit = 1'b1;
        return hit;
    endfunction

    function automatic logic [7:0] sfr_reset_val(input logic [7:0] a);
        if (a == ADR_STACK) return 8'h07;
        if (a == 8'h80 || a == 8'h90 || a == 8'hA0 || a == 8'hB0) return 8'hFF;
        return 8'h00;
    endfunction

    function automatic logic [DW-1:0] bit_merge(input op_e op, input logic [DW-1:0] old,
                                                input logic [2:0] pos);
        logic [DW-1:0] nv;
        nv = old;
        case (op)
            OP_BIT_SET:             nv[pos] = 1'b1;
            OP_BIT_CLR, OP_BIT_TCL: nv[pos] = 1'b0;
            OP_BIT_CPL:             nv[pos] = ~old[pos];
            default:                nv = old;
        endcase
        return nv;
    endfunction

endpackage

// File: rtl/idata_ram.sv
module idata_ram #(
    parameter int DEPTH = 128,
    parameter int W     = 8,
    parameter int NRD   = 1,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [AW-1:0]          waddr,
    input  logic [W-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0] raddr,
    output logic [NRD-1:0][W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end
endmodule

// File: rtl/idata_sfr_file.sv
module idata_sfr_file
    import idata_pkg::*;
#(
    parameter int N = NUM_SFR,
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [7:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic [1:0]   bank_o
);
    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst)
                regs[i] <= sfr_reset_val(sfr_slot_addr(i));
            else if (we && addr == sfr_slot_addr(i))
                regs[i] <= wdata;
        end
    end

    always_comb begin
        rdata  = '0;
        bank_o = '0;
        for (int i = 0; i < N; i++) begin
            if (addr == sfr_slot_addr(i))       rdata  = regs[i];
            if (sfr_slot_addr(i) == ADR_STATUS) bank_o = regs[i][4:3];
        end
    end
endmodule

// File: rtl/idata_resolve.sv
module idata_resolve
    import idata_pkg::*;
(
    input  op_e        op,
    input  logic [7:0] addr,
    input  logic [2:0] rsel,
    input  logic [1:0] bank,
    input  logic [7:0] ptr,
    output acc_t       acc
);
    logic [7:0] sfr_base;
    assign sfr_base = {addr[7:3], 3'b000};

    always_comb begin
        acc     = '0;
        acc.tgt = TGT_NONE;
        case (op)
            OP_DIR_RD, OP_DIR_WR: begin
                acc.addr = addr;
                acc.rd   = (op == OP_DIR_RD);
                acc.wr   = (op == OP_DIR_WR);
                if (!addr[7])               acc.tgt = TGT_LO;
                else if (sfr_is_impl(addr)) acc.tgt = TGT_SFR;
                else                        acc.err = 1'b1;
            end
            OP_IND_RD, OP_IND_WR: begin
                if (rsel[2:1] != 2'b00) begin
                    acc.err = 1'b1;
                end else begin
                    acc.addr = ptr;
                    acc.rd   = (op == OP_IND_RD);
                    acc.wr   = (op == OP_IND_WR);
                    acc.tgt  = ptr[7] ? TGT_HI : TGT_LO;
                end
            end
            OP_REG_RD, OP_REG_WR: begin
                acc.addr = {3'b000, bank, rsel};
                acc.rd   = (op == OP_REG_RD);
                acc.wr   = (op == OP_REG_WR);
                acc.tgt  = TGT_LO;
            end
            OP_BIT_RD, OP_BIT_SET, OP_BIT_CLR, OP_BIT_CPL, OP_BIT_TCL: begin
                acc.is_bit = 1'b1;
                acc.bpos   = addr[2:0];
                acc.wr     = (op != OP_BIT_RD);
                if (!addr[7]) begin
                    acc.addr = {4'h2, addr[6:3]};
                    acc.tgt  = TGT_LO;
                end else if (sfr_is_impl(sfr_base)) begin
                    acc.addr = sfr_base;
                    acc.tgt  = TGT_SFR;
                end else begin
                    acc.wr  = 1'b0;
                    acc.err = 1'b1;
                end
            end
            default: acc = '0;
        endcase
    end
endmodule

// File: rtl/idata_space.sv
module idata_space
    import idata_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] op_i,
    input  logic [7:0] addr_i,
    input  logic [2:0] rsel_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic       bit_o,
    output logic       err_o
);
    op_e                      op;
    acc_t                     acc;
    logic [1:0]               bank;
    logic [1:0][RAM_AW-1:0]   lo_raddr;
    logic [1:0][DW-1:0]       lo_rdata;
    logic [0:0][RAM_AW-1:0]   hi_raddr;
    logic [0:0][DW-1:0]       hi_rdata;
    logic [DW-1:0]            sfr_rdata;
    logic [DW-1:0]            old_byte;
    logic [DW-1:0]            new_byte;

    assign op = op_e'(op_i);

    // Port 0 fetches the pointer register, port 1 the data byte.
    assign lo_raddr[0] = RAM_AW'({bank, 2'b00, rsel_i[0]});
    assign lo_raddr[1] = acc.addr[RAM_AW-1:0];
    assign hi_raddr[0] = acc.addr[RAM_AW-1:0];

    idata_resolve u_resolve (
        .op   (op),
        .addr (addr_i),
        .rsel (rsel_i),
        .bank (bank),
        .ptr  (lo_rdata[0]),
        .acc  (acc)
    );

    idata_ram #(.DEPTH(RAM_DEPTH), .W(DW), .NRD(2)) u_lo_ram (
        .clk   (clk),
        .we    (acc.wr && acc.tgt == TGT_LO),
        .waddr (acc.addr[RAM_AW-1:0]),
        .wdata (new_byte),
        .raddr (lo_raddr),
        .rdata (lo_rdata)
    );

    idata_ram #(.DEPTH(RAM_DEPTH), .W(DW), .NRD(1)) u_hi_ram (
        .clk   (clk),
        .we    (acc.wr && acc.tgt == TGT_HI),
        .waddr (acc.addr[RAM_AW-1:0]),
        .wdata (new_byte),
        .raddr (hi_raddr),
        .rdata (hi_rdata)
    );

    idata_sfr_file u_sfr (
        .clk    (clk),
        .rst    (rst),
        .we     (acc.wr && acc.tgt == TGT_SFR),
        .addr   (acc.addr),
        .wdata  (new_byte),
        .rdata  (sfr_rdata),
        .bank_o (bank)
    );

    always_comb begin
        case (acc.tgt)
            TGT_LO:  old_byte = lo_rdata[1];
            TGT_HI:  old_byte = hi_rdata[0];
            TGT_SFR: old_byte = sfr_rdata;
            default: old_byte = '0;
        endcase
    end

    assign new_byte = acc.is_bit ? bit_merge(op, old_byte, acc.bpos) : wdata_i;
    assign rdata_o  = (acc.rd && !acc.is_bit) ? old_byte : '0;
    assign bit_o    = (acc.is_bit && acc.tgt != TGT_NONE) ? old_byte[acc.bpos] : 1'b0;
    assign err_o    = acc.err;
endmodule

// File: rtl/idata_space_chk.sv
module idata_space_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] op_i,
    input logic [7:0] addr_i,
    input logic [2:0] rsel_i,
    input logic [7:0] rdata_o,
    input logic       bit_o,
    input logic       err_o
);
    AST_STACK_RESET: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && op_i == 4'd1 && addr_i == 8'h81) |-> rdata_o == 8'h07) // R8
        else $error("stack register reset value wrong");

    AST_BAD_POINTER: assert property (@(posedge clk) disable iff (rst)
        ((op_i == 4'd3 || op_i == 4'd4) && rsel_i > 3'd1) |-> (err_o && rdata_o == 8'h00)) // R5
        else $error("illegal pointer not flagged");

    AST_RESERVED_READ: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd1 && addr_i == 8'hC0) |-> (err_o && rdata_o == 8'h00)) // R7
        else $error("reserved register read not flagged");

    AST_TCL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd8 && $past(op_i) == 4'd12 && addr_i == $past(addr_i) && !$past(err_o))
        |-> !bit_o) // R6
        else $error("test-and-clear left bit set");

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd8 && $past(op_i) == 4'd9 && addr_i == $past(addr_i) && !$past(err_o))
        |-> bit_o) // R9
        else $error("set bit not visible next cycle");

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd0) |-> (!err_o && !bit_o && rdata_o == 8'h00)) // R10
        else $error("idle op produced output");
endmodule

bind idata_space idata_space_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .op_i    (op_i),
    .addr_i  (addr_i),
    .rsel_i  (rsel_i),
    .rdata_o (rdata_o),
    .bit_o   (bit_o),
    .err_o   (err_o)
);

// File: tb/idata_space_tb_top.sv
module idata_space_tb_top;
    localparam time CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_i = 4'd0;
    logic [7:0] addr_i = 8'h00;
    logic [2:0] rsel_i = 3'd0;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] rdata_o;
    logic       bit_o;
    logic       err_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        string      req;
        logic [3:0] op;
        logic [7:0] a;
        logic [7:0] xd;
        logic       xb;
        logic       xe;
    } exp_t;
    exp_t q[$];

    logic [7:0] lo [128];
    logic [7:0] hi [128];
    logic [7:0] msfr [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    idata_space dut_i (
        .clk(clk), .rst(rst), .op_i(op_i), .addr_i(addr_i), .rsel_i(rsel_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .bit_o(bit_o), .err_o(err_o)
    );

    function automatic bit impl(input logic [7:0] a);
        case (a)
            8'h80, 8'h81, 8'h82, 8'h83, 8'h87, 8'h88, 8'h89, 8'h8A, 8'h8B,
            8'h8C, 8'h8D, 8'h90, 8'h98, 8'h99, 8'hA0, 8'hA8, 8'hB0, 8'hB8,
            8'hD0, 8'hE0, 8'hF0: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic do_op(input logic [3:0] op, input logic [7:0] a, input logic [2:0] rs,
                         input logic [7:0] wd, input string req);
        exp_t e;
        logic [1:0] bk;
        logic [7:0] p, ba, ob;
        logic [6:0] li;
        logic [2:0] pos;
        @(posedge clk); #1;
        op_i = op; addr_i = a; rsel_i = rs; wdata_i = wd;
        e.req = req; e.op = op; e.a = a; e.xd = 8'h00; e.xb = 1'b0; e.xe = 1'b0;
        bk = msfr[8'hD0][4:3];
        case (op)
            4'd1: if (!a[7]) e.xd = lo[a[6:0]];
                  else if (impl(a)) e.xd = msfr[a];
                  else e.xe = 1'b1;
            4'd2: if (!a[7]) lo[a[6:0]] = wd;
                  else if (impl(a)) msfr[a] = wd;
                  else e.xe = 1'b1;
            4'd3, 4'd4: begin
                if (rs > 3'd1) e.xe = 1'b1;
                else begin
                    p = lo[{2'b00, bk, 2'b00, rs[0]}];
                    if (op == 4'd3) e.xd = p[7] ? hi[p[6:0]] : lo[p[6:0]];
                    else if (p[7]) hi[p[6:0]] = wd;
                    else lo[p[6:0]] = wd;
                end
            end
            4'd5: e.xd = lo[{2'b00, bk, rs}];
            4'd6: lo[{2'b00, bk, rs}] = wd;
            4'd8, 4'd9, 4'd10, 4'd11, 4'd12: begin
                pos = a[2:0];
                ba  = {a[7:3], 3'b000};
                li  = 7'h20 + 7'(a[6:3]);
                if (a[7] && !impl(ba)) e.xe = 1'b1;
                else begin
                    ob = a[7] ? msfr[ba] : lo[li];
                    e.xb = ob[pos];
                    case (op)
                        4'd9:        ob[pos] = 1'b1;
                        4'd10, 4'd12: ob[pos] = 1'b0;
                        4'd11:       ob[pos] = ~ob[pos];
                        default:     ob = ob;
                    endcase
                    if (a[7]) msfr[ba] = ob; else lo[li] = ob;
                end
            end
            default: ;
        endcase
        q.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (rdata_o !== e.xd || bit_o !== e.xb || err_o !== e.xe) begin
                    failures++;
                    $display("FAIL %s op=%0d addr=%02h: actual data=%02h bit=%0b err=%0b expected data=%02h bit=%0b err=%0b",
                             e.req, e.op, e.a, rdata_o, bit_o, err_o, e.xd, e.xb, e.xe);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: actual running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stimulus
        for (int i = 0; i < 256; i++) msfr[i] = 8'h00;
        msfr[8'h81] = 8'h07;
        msfr[8'h80] = 8'hFF; msfr[8'h90] = 8'hFF; msfr[8'hA0] = 8'hFF; msfr[8'hB0] = 8'hFF;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R8 / R7: reset values and reserved addresses across the whole upper space
        do_op(4'd1, 8'h81, 3'd0, 8'h00, "R8");
        for (int a = 128; a < 256; a++) do_op(4'd1, 8'(a), 3'd0, 8'h00, impl(8'(a)) ? "R8" : "R7");

        // R3: fill lower RAM directly, upper RAM through R0 (bank 0)
        for (int a = 0; a < 128; a++) do_op(4'd2, 8'(a), 3'd0, 8'(a * 3 + 5), "R3");
        for (int a = 0; a < 128; a++) begin
            do_op(4'd6, 8'h00, 3'd0, 8'(128 + a), "R4");
            do_op(4'd4, 8'h00, 3'd0, 8'(8'hA5 ^ a), "R3");
        end
        for (int a = 0; a < 128; a += 7) do_op(4'd1, 8'(a), 3'd0, 8'h00, "R3");
        for (int a = 0; a < 128; a += 5) begin
            do_op(4'd6, 8'h00, 3'd1, 8'(128 + a), "R4");
            do_op(4'd3, 8'h00, 3'd1, 8'h00, "R3");
        end
        // R3: direct 90h versus pointer 90h
        do_op(4'd2, 8'h90, 3'd0, 8'h3C, "R3");
        do_op(4'd6, 8'h00, 3'd0, 8'h90, "R3");
        do_op(4'd4, 8'h00, 3'd0, 8'hC3, "R3");
        do_op(4'd1, 8'h90, 3'd0, 8'h00, "R3");
        do_op(4'd3, 8'h00, 3'd0, 8'h00, "R3");
        do_op(4'd6, 8'h00, 3'd0, 8'h44, "R3");
        do_op(4'd3, 8'h00, 3'd0, 8'h00, "R3");

        // R4 / R9: every bank, switched by byte write then used the next cycle
        for (int b = 0; b < 4; b++) begin
            do_op(4'd2, 8'hD0, 3'd0, 8'(b << 3), "R9");
            for (int r = 0; r < 8; r++) do_op(4'd6, 8'h00, 3'(r), 8'(16 * b + r + 1), "R4");
            for (int r = 0; r < 8; r++) do_op(4'd5, 8'h00, 3'(r), 8'h00, "R4");
        end
        for (int a = 0; a < 32; a++) do_op(4'd1, 8'(a), 3'd0, 8'h00, "R4");
        do_op(4'd11, 8'hD3, 3'd0, 8'h00, "R4");
        do_op(4'd5, 8'h00, 3'd2, 8'h00, "R4");
        do_op(4'd2, 8'hD0, 3'd0, 8'h00, "R4");

        // R5: illegal pointer registers
        for (int r = 2; r < 8; r++) begin
            do_op(4'd4, 8'h00, 3'(r), 8'hEE, "R5");
            do_op(4'd3, 8'h00, 3'(r), 8'h00, "R5");
        end
        for (int a = 0; a < 128; a += 9) do_op(4'd1, 8'(a), 3'd0, 8'h00, "R5");

        // R7: reserved writes are ignored
        do_op(4'd2, 8'hC0, 3'd0, 8'h5A, "R7");
        do_op(4'd2, 8'hFF, 3'd0, 8'h5A, "R7");
        do_op(4'd1, 8'hC0, 3'd0, 8'h00, "R7");
        do_op(4'd1, 8'hFF, 3'd0, 8'h00, "R7");

        // R1 / R2 / R6: full bit-address sweep
        for (int b = 0; b < 256; b++) begin
            if (b[7:3] == 5'b11010) continue;
            do_op(4'd9,  8'(b), 3'd0, 8'h00, b < 128 ? "R1" : "R2");
            do_op(4'd8,  8'(b), 3'd0, 8'h00, "R6");
            do_op(4'd11, 8'(b), 3'd0, 8'h00, "R6");
            do_op(4'd12, 8'(b), 3'd0, 8'h00, "R6");
            do_op(4'd8,  8'(b), 3'd0, 8'h00, "R6");
            do_op(4'd10, 8'(b), 3'd0, 8'h00, "R6");
        end
        for (int a = 32; a < 48; a++) do_op(4'd1, 8'(a), 3'd0, 8'h00, "R1");
        for (int a = 128; a < 256; a += 8) do_op(4'd1, 8'(a), 3'd0, 8'h00, "R2");

        // R9: back-to-back bit operations on one byte
        do_op(4'd2, 8'h2A, 3'd0, 8'h00, "R9");
        do_op(4'd9, 8'h50, 3'd0, 8'h00, "R9");
        do_op(4'd11, 8'h51, 3'd0, 8'h00, "R9");
        do_op(4'd12, 8'h50, 3'd0, 8'h00, "R9");
        do_op(4'd8, 8'h51, 3'd0, 8'h00, "R9");
        do_op(4'd1, 8'h2A, 3'd0, 8'h00, "R9");

        // R10: idle and unused codes
        do_op(4'd0, 8'h30, 3'd0, 8'hAA, "R10");
        do_op(4'd7, 8'h30, 3'd0, 8'hAA, "R10");
        do_op(4'd13, 8'h30, 3'd0, 8'hAA, "R10");
        do_op(4'd15, 8'h30, 3'd0, 8'hAA, "R10");
        do_op(4'd2, 8'h30, 3'd0, 8'h11, "R10");
        do_op(4'd1, 8'h30, 3'd0, 8'h00, "R10");

        @(posedge clk); #1 op_i = 4'd0;
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule